// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a byte-wide, register-mapped general-purpose I/O port for a small 8-bit controller. Software reaches it through a simple register bus carrying an address, a write strobe, a read strobe and 8-bit data. Three registers sit behind the bus. The drive-level register and the direction register can be read and written. The sampled-level register can only be read; writing ones to it flips bits of the drive-level register.

For every implemented pin the block produces three registered signals: an output enable, an output value and a pull-up enable. A pad cell outside the block uses them. The pin levels enter through a two-stage synchronizer. A global pull-up kill input turns the pull-ups off on every pin. Each pin also has its own override inputs, which let a peripheral take over that pin's direction, value and pull-up without changing the registers or the other pins.

Top module: `gpio_port`

## Requirements
- R1: After reset, the drive-level and direction registers read zero, every pad output enable is 0 and every pull-up enable is 0.
- R2: The drive-level register is at address 0 and the direction register is at address 1. Both read back what was written, in bits 5:0. Bits 7:6 always read as zero and ignore writes. Address 3 reads as zero and ignores writes. Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.
- R3: Address 2 returns the pad levels as they stood two clock edges before the read edge, through a 2-flop synchronizer. A read issued one edge after a pad change still returns the old level.
- R4: A write to address 2 inverts each drive-level bit whose data bit is 1 and leaves the bits written 0 unchanged. It changes neither the direction register nor the value later read from address 2.
- R5: Without override, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals drive-level bit i. Both are registered one cycle after the register changes.
- R6: Without override, `pad_pu[i]` is 1 only when direction bit i is 0, drive-level bit i is 1 and `pu_kill` is 0. A pin never has its output enable and its pull-up enable set together.
- R7: While `pu_kill` is 1, every `pad_pu` bit is 0 from the next cycle on, whatever the registers or the override inputs hold.
- R8: When `ovr_en[i]` is 1, pin i takes its output enable, output value and pull-up from `ovr_dir[i]`, `ovr_out[i]` and `ovr_pull[i]`. The registers keep their contents, and the other pins keep their register-derived behaviour.
- R9: When a read and a write hit the same cycle, the read returns the value from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pu_kill | input | 1 | Global pull-up disable |
| ovr_en | input | 6 | Per-pin override select |
| ovr_dir | input | 6 | Override output enable |
| ovr_out | input | 6 | Override output value |
| ovr_pull | input | 6 | Override pull-up request |
| pad_in | input | 6 | Raw pad levels |
| pad_oe | output | 6 | Pad output enable |
| pad_out | output | 6 | Pad output value |
| pad_pu | output | 6 | Pad pull-up enable |

## Verification
The sharpest collision happens when software reads a register and writes to it in one bus cycle. The bench asserts both strobes together on address 2 with a toggle mask, and again on address 0 with new data. The first read must return the synchronized pad levels and the second must return the old drive level. A later read of address 0 must then show the toggled bits or the new data. The bench also changes the pad levels one edge before a read, which separates the synchronizer delay from the read latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    A_DRIVE = 2'd0,
    A_DIR   = 2'd1,
    A_LEVEL = 2'd2,
    A_SPARE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  gpio_addr_e          addr,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_bits,
  output logic [NUM_PINS-1:0] drive_q,
  output logic [NUM_PINS-1:0] dir_q
);
  logic [NUM_PINS-1:0] drive_d, dir_d;
  logic                rst_seen;

  always_comb begin
    drive_d = drive_q;
    dir_d   = dir_q;
    if (wr_en) begin
      unique case (addr)
        A_DRIVE: drive_d = wr_bits;
        A_DIR:   dir_d   = wr_bits;
        A_LEVEL: drive_d = drive_q ^ wr_bits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      dir_q   <= '0;
    end else begin
      drive_q <= drive_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_seen && !rst) begin
      reset_clear_chk: assert (drive_q == '0 && dir_q == '0)
        else $error("registers not cleared by reset");
    end
  end

  // R4
  toggle_keeps_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_LEVEL) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic reg_dir,
  input  logic reg_drive,
  input  logic pu_kill,
  input  logic ovr_en,
  input  logic ovr_dir,
  input  logic ovr_out,
  input  logic ovr_pull,
  output logic oe_q,
  output logic out_q,
  output logic pu_q
);
  logic oe_d, out_d, pu_req, pu_d;

  always_comb begin
    if (ovr_en) begin
      oe_d   = ovr_dir;
      out_d  = ovr_out;
      pu_req = ovr_pull;
    end else begin
      oe_d   = reg_dir;
      out_d  = reg_drive;
      pu_req = ~reg_dir & reg_drive;
    end
    pu_d = pu_req & ~pu_kill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      pu_q  <= pu_d;
    end
  end

  // R7
  pull_kill_chk: assert property (@(posedge clk) disable iff (rst)
    pu_kill |=> !pu_q);

  // R6
  oe_pu_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr_en |=> !(oe_q && pu_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic                pu_kill,
  input  logic [NUM_PINS-1:0] ovr_en,
  input  logic [NUM_PINS-1:0] ovr_dir,
  input  logic [NUM_PINS-1:0] ovr_out,
  input  logic [NUM_PINS-1:0] ovr_pull,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu
);
  gpio_addr_e          addr_e;
  logic [NUM_PINS-1:0] drive_q, dir_q, level_s;
  logic [REG_W-1:0]    rd_mux;

  assign addr_e = gpio_addr_e'(addr);

  if (REG_W > NUM_PINS) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wr_data[REG_W-1:NUM_PINS];
  end

  gpio_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr_e),
    .wr_en   (wr_en),
    .wr_bits (wr_data[NUM_PINS-1:0]),
    .drive_q (drive_q),
    .dir_q   (dir_q)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (level_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_cell cell_i (
      .clk       (clk),
      .rst       (rst),
      .reg_dir   (dir_q[i]),
      .reg_drive (drive_q[i]),
      .pu_kill   (pu_kill),
      .ovr_en    (ovr_en[i]),
      .ovr_dir   (ovr_dir[i]),
      .ovr_out   (ovr_out[i]),
      .ovr_pull  (ovr_pull[i]),
      .oe_q      (pad_oe[i]),
      .out_q     (pad_out[i]),
      .pu_q      (pad_pu[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_e)
      A_DRIVE: rd_mux[NUM_PINS-1:0] = drive_q;
      A_DIR:   rd_mux[NUM_PINS-1:0] = dir_q;
      A_LEVEL: rd_mux[NUM_PINS-1:0] = level_s;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R2
  spare_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_e == A_SPARE) |=> rd_data == '0);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pu_kill = 1'b0;
  logic [5:0] ovr_en = '0, ovr_dir = '0, ovr_out = '0, ovr_pull = '0;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_oe, pad_out, pad_pu;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .pu_kill(pu_kill),
    .ovr_en(ovr_en), .ovr_dir(ovr_dir), .ovr_out(ovr_out), .ovr_pull(ovr_pull),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
    check("R1 pad_pu", {2'b0, pad_pu}, 8'h00);
    bus_read(2'd0, d); check("R1 drive", d, 8'h00);
    bus_read(2'd1, d); check("R1 dir", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    bus_write(2'd0, 8'h2A); bus_read(2'd0, d); check("R2 drive rw", d, 8'h2A);
    bus_write(2'd1, 8'hFF); bus_read(2'd1, d); check("R2 dir upper bits", d, 8'h3F);
    bus_write(2'd3, 8'h55); bus_read(2'd3, d); check("R2 spare addr", d, 8'h00);
    bus_read(2'd0, d); check("R2 spare write ignored", d, 8'h2A);
    @(negedge clk); check("R2 rd_data holds", rd_data, 8'h2A);
  endtask

  task automatic t_pads;
    bus_write(2'd1, 8'h0F); bus_write(2'd0, 8'h35);
    @(negedge clk);
    check("R5 pad_oe", {2'b0, pad_oe}, 8'h0F);
    check("R5 pad_out", {2'b0, pad_out}, 8'h35);
    check("R6 pad_pu", {2'b0, pad_pu}, 8'h30);
  endtask

  task automatic t_kill;
    pu_kill = 1'b1; ovr_en = 6'h01; ovr_pull = 6'h01; ovr_dir = '0;
    @(negedge clk);
    check("R7 pull-ups killed", {2'b0, pad_pu}, 8'h00);
    pu_kill = 1'b0; ovr_en = '0; ovr_pull = '0;
    @(negedge clk);
    check("R7 pull-ups restored", {2'b0, pad_pu}, 8'h30);
  endtask

  task automatic t_toggle;
    logic [7:0] d;
    pad_in = 6'h2C;
    repeat (2) @(negedge clk);
    bus_write(2'd2, 8'h0F); bus_read(2'd0, d); check("R4 toggle ones", d, 8'h3A);
    bus_write(2'd2, 8'h00); bus_read(2'd0, d); check("R4 zeros keep", d, 8'h3A);
    bus_read(2'd1, d); check("R4 dir untouched", d, 8'h0F);
    bus_read(2'd2, d); check("R4 level unaffected", d, 8'h2C);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    pad_in = 6'h15;
    @(negedge clk);
    bus_read(2'd2, d); check("R3 one edge too early", d, 8'h2C);
    bus_read(2'd2, d); check("R3 after two edges", d, 8'h15);
  endtask

  task automatic t_ovr;
    logic [7:0] d;
    ovr_en = 6'h01; ovr_dir = 6'h01; ovr_out = 6'h00; ovr_pull = 6'h00;
    @(negedge clk);
    check("R8 oe override", {2'b0, pad_oe}, 8'h0F);
    check("R8 out override", {2'b0, pad_out}, 8'h3A);
    ovr_dir = 6'h00; ovr_pull = 6'h01;
    @(negedge clk);
    check("R8 pu override", {2'b0, pad_pu}, 8'h31);
    check("R8 other oe", {2'b0, pad_oe}, 8'h0E);
    bus_read(2'd1, d); check("R8 dir kept", d, 8'h0F);
    ovr_en = '0; ovr_pull = '0;
    @(negedge clk);
    check("R8 released", {2'b0, pad_oe}, 8'h0F);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    addr = 2'd2; wr_data = 8'h3F; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 level read on toggle", rd_data, 8'h15);
    bus_read(2'd0, d); check("R9 toggle applied", d, 8'h05);
    addr = 2'd0; wr_data = 8'h11; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 old drive returned", rd_data, 8'h05);
    bus_read(2'd0, d); check("R9 new drive stored", d, 8'h11);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset(); t_regs(); t_pads(); t_kill();
        t_toggle(); t_sync(); t_ovr(); t_same_cycle();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule